// File: doc/BRIEF.md
# Dual-Channel Compare Timer with 64-bit Join

This block is a memory-mapped timer that sits on an APB bus. It holds two 32-bit counting channels, called low and high. Each channel has a configuration word, a count word and a compare word. Each channel also has two write-only addresses: one starts the channel and one clears its count. A channel advances on every bus clock, or only on rising edges of a reference clock input. An optional 8-bit prescaler can be placed in front of the counter, so that the channel advances only once per several base events. When the count lands on the compare value, the channel's interrupt output pulses. The channel can then return to zero and keep running, or it can disable itself.

Bit 31 of the low configuration word joins the two channels into one 64-bit counter. In this mode the low channel's prescaler and enable drive the counter. The high count word supplies the upper 32 bits, and the compare value is joined the same way. Only the low interrupt output is used. If bit 30 is also set, the low interrupt becomes a level that is high whenever the 64-bit count is greater than or equal to the 64-bit compare value. This level does not depend on the interrupt enable bit. Software may rewrite any count word at any time, including while the counter is running.

Top module: `tmr_apb_dual`

## Requirements
- R1: The APB slave completes every transfer with no wait states (pready_o=1) and pslverr_o=0. The word addresses are: config low 0x00, config high 0x04, count low 0x08, count high 0x0C, compare low 0x10, compare high 0x14, start low 0x18, start high 0x1C, clear low 0x20, clear high 0x24. A config word reads back as the written value masked to 0xC000FFFD. Unmapped addresses read 0.
- R2: Config bit 0 enables counting. A channel with bit 0 set and no prescaler (bit 6=0) and no reference clock (bit 7=0) advances by one on every bus clock edge. With bit 0 clear, the count holds.
- R3: With config bit 6 set, the channel advances once per (D+1) base events, where D is config bits 15:8. With bit 6 clear, D has no effect.
- R4: With config bit 7 set, the base event is a rising edge of ref_clk_i, seen after a two-flop synchronizer. Each rising edge advances the count by one.
- R5: When an advance makes the count equal to the compare value and config bit 2 is set, the channel's interrupt output is high for exactly one cycle. With config bit 4 set, an advance taken while count equals compare returns the count to 0, so the cycle length is compare+1.
- R6: With config bit 5 set, the advance that lands on the compare value also clears config bit 0. The count then stays at the compare value.
- R7: With low config bit 31 set, the counter is {count high, count low}. The high word increments when the low word wraps. Only irq_lo_o can signal, and irq_hi_o stays low.
- R8: In 64-bit mode with compare-clear set, the counter clears both words together once the 64-bit count equals the 64-bit compare value.
- R9: In 64-bit mode with low config bit 30 set, irq_lo_o is a level equal to ({count}>={compare}), delayed by one cycle. It does not depend on config bit 2 or bit 0.
- R10: A write to a start address sets that channel's config bit 0. A write to a clear address sets that channel's count to 0. Neither address stores data, and both read 0.
- R11: busy_o is high exactly when config bit 0 of either channel is set.
- R12: A write to a count word replaces the count, even while the channel is running, and counting continues from the written value. Writing config with bit 1 set zeroes the count, and bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Synchronous active-low reset |
| paddr | input | ADDR_W | Byte address |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Transfer done, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| irq_lo_o | output | 1 | Low-channel (or 64-bit) interrupt |
| irq_hi_o | output | 1 | High-channel interrupt |
| busy_o | output | 1 | A channel is enabled |

## Verification
A write takes effect at the clock edge of its access phase. Counting starts at the next edge and stops at the edge of the disabling write. With the bench's three-edge bus tasks, a run with D idle cycles between the two writes therefore covers exactly D+3 base events. Every expected count and interrupt total is computed from that figure, the prescaler divisor and the compare value. The interrupt pulse is registered at the same edge as the count that caused it. The mtime level follows the count one edge later, so the bench allows two extra idle cycles before it samples that level. Reference-clock runs allow four bus cycles after the last rising edge for the synchronizer, and outputs are read half a cycle after the edge.

// File: rtl/tmr_pkg.sv
// Shared constants of the dual timer: word indices of the register map
// and bit positions inside a configuration word.
package tmr_pkg;
    localparam int NREG      = 10;
    localparam int RI_CFG    = 0;   // +0 low, +1 high
    localparam int RI_CNT    = 2;
    localparam int RI_CMP    = 4;
    localparam int RI_GO     = 6;
    localparam int RI_CLR    = 8;

    localparam int B_EN      = 0;
    localparam int B_RST     = 1;
    localparam int B_IRQ     = 2;
    localparam int B_EVT     = 3;
    localparam int B_WRAP    = 4;
    localparam int B_ONCE    = 5;
    localparam int B_PRE     = 6;
    localparam int B_REF     = 7;
    localparam int B_DIV     = 8;
endpackage

// File: rtl/tmr_ref_edge.sv
// Synchronises the asynchronous reference clock into the bus domain and
// emits a one-cycle pulse per rising edge. Assumes the reference runs at
// less than half the bus clock rate.
module tmr_ref_edge #(
    parameter int SYNC = 2
) (
    input  logic pclk,
    input  logic presetn,
    input  logic ref_i,
    output logic rise_o
);
    logic [SYNC:0] sh_q;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge pclk) begin
        if (!presetn) sh_q <= '0;
        else          sh_q <= {sh_q[SYNC-1:0], ref_i};
    end

    assign rise_o = sh_q[SYNC-1] & ~sh_q[SYNC];
endmodule

// File: rtl/tmr_tick_gen.sv
// Per-channel advance generator: picks the base event (every bus clock or a
// reference rising edge) and optionally divides it by div+1. Assumes div
// is changed only while the channel is stopped or cleared.
module tmr_tick_gen #(
    parameter int PW = 8
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          run,
    input  logic          ref_sel,
    input  logic          ref_rise,
    input  logic          pre_sel,
    input  logic [PW-1:0] div,
    input  logic          clr,
    output logic          tick
);
    logic [PW-1:0] pc_q;
    logic          step, wrap;

    assign step = run & (ref_sel ? ref_rise : 1'b1);
    assign wrap = (pc_q == div);
    assign tick = step & (~pre_sel | wrap);

    // Prescaler count: runs on base events, restarts on wrap or clear.
    always_ff @(posedge pclk) begin
        if (!presetn)            pc_q <= '0;
        else if (clr)            pc_q <= '0;
        else if (step && pre_sel) pc_q <= wrap ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/tmr_apb_if.sv
// APB decode and read mux. Produces one write strobe per register word and
// the read data. Assumes word-aligned addresses; anything else is unmapped.
module tmr_apb_if
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DW     = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     cfg_lo,
    input  logic [DW-1:0]     cfg_hi,
    input  logic [DW-1:0]     cnt_lo,
    input  logic [DW-1:0]     cnt_hi,
    input  logic [DW-1:0]     cmp_lo,
    input  logic [DW-1:0]     cmp_hi,
    output logic [NREG-1:0]   wr,
    output logic [DW-1:0]     rdata
);
    logic [3:0] idx;
    logic       in_map;

    assign idx    = paddr[5:2];
    assign in_map = (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:6] == '0)
                    && (int'(idx) < NREG);

    for (genvar i = 0; i < NREG; i++) begin : g_wr
        assign wr[i] = psel & penable & pwrite & in_map & (int'(idx) == i);
    end

    // Read mux; strobe words and holes read zero.
    always_comb begin
        rdata = '0;
        if (in_map) begin
            case (int'(idx))
                RI_CFG:     rdata = cfg_lo;
                RI_CFG + 1: rdata = cfg_hi;
                RI_CNT:     rdata = cnt_lo;
                RI_CNT + 1: rdata = cnt_hi;
                RI_CMP:     rdata = cmp_lo;
                RI_CMP + 1: rdata = cmp_hi;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_apb_dual.sv
// Dual 32-bit compare timer with optional 64-bit join and mtime level
// interrupt. Channel 0 is low, channel 1 is high. In joined mode channel 0's
// enable, prescaler and mode bits rule and channel 1's counting is idle.
// Assumes DW = 32 so that the two mode bits sit at the top of the word.
module tmr_apb_dual
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DW     = 32,
    parameter int PW     = 8,
    parameter int SYNC   = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ref_clk_i,
    output logic              irq_lo_o,
    output logic              irq_hi_o,
    output logic              busy_o
);
    localparam int B_MT  = DW - 2;
    localparam int B_64  = DW - 1;
    localparam logic [DW-1:0] KEEP =
        {2'b11, {(DW-18){1'b0}}, 16'hFFFD};
    localparam int W64 = 2 * DW;

    logic [NREG-1:0] wr;
    logic [DW-1:0]   cfg_q [2];
    logic [DW-1:0]   cnt_q [2];
    logic [DW-1:0]   cmp_q [2];
    logic [DW-1:0]   cnt_d [2];
    logic [DW-1:0]   nxt32 [2];
    logic [1:0]      tick, land, rst_own, rst_all, irqp_q;
    logic [W64-1:0]  cnt64, cmp64, nxt64;
    logic            m64, mt, mt_q, rise;
    logic [DW-1:0]   cfg_lo_w, cfg_hi_w, cnt_lo_w, cnt_hi_w;

    assign m64 = cfg_q[0][B_64];
    assign mt  = cfg_q[0][B_MT];
    assign cfg_lo_w = cfg_q[0];
    assign cfg_hi_w = cfg_q[1];
    assign cnt_lo_w = cnt_q[0];
    assign cnt_hi_w = cnt_q[1];

    tmr_apb_if #(.ADDR_W(ADDR_W), .DW(DW)) u_if (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .cfg_lo(cfg_q[0]), .cfg_hi(cfg_q[1]),
        .cnt_lo(cnt_q[0]), .cnt_hi(cnt_q[1]),
        .cmp_lo(cmp_q[0]), .cmp_hi(cmp_q[1]),
        .wr(wr), .rdata(prdata)
    );

    tmr_ref_edge #(.SYNC(SYNC)) u_ref (
        .pclk(pclk), .presetn(presetn), .ref_i(ref_clk_i), .rise_o(rise)
    );

    // Clear requests: strobe or config reset bit; low clear reaches both in 64-bit mode.
    always_comb begin
        for (int c = 0; c < 2; c++)
            rst_own[c] = wr[RI_CLR + c] | (wr[RI_CFG + c] & pwdata[B_RST]);
        rst_all[0] = rst_own[0];
        rst_all[1] = rst_own[1] | (m64 & rst_own[0]);
    end

    // Next-count, landing and compare arithmetic for both widths.
    always_comb begin
        cnt64 = {cnt_q[1], cnt_q[0]};
        cmp64 = {cmp_q[1], cmp_q[0]};
        nxt64 = (cfg_q[0][B_WRAP] && cnt64 == cmp64) ? '0 : cnt64 + 1'b1;
        for (int c = 0; c < 2; c++)
            nxt32[c] = (cfg_q[c][B_WRAP] && cnt_q[c] == cmp_q[c]) ? '0
                                                                   : cnt_q[c] + 1'b1;
        land[0] = m64 ? (tick[0] && nxt64 == cmp64)
                      : (tick[0] && nxt32[0] == cmp_q[0]);
        land[1] = !m64 && tick[1] && nxt32[1] == cmp_q[1];
        for (int c = 0; c < 2; c++) begin
            cnt_d[c] = cnt_q[c];
            if (rst_all[c])               cnt_d[c] = '0;
            else if (wr[RI_CNT + c])      cnt_d[c] = pwdata;
            else if (m64 && tick[0])      cnt_d[c] = nxt64[c*DW +: DW];
            else if (!m64 && tick[c])     cnt_d[c] = nxt32[c];
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic run;
        assign run = cfg_q[c][B_EN] & ~((c == 1) & m64);

        tmr_tick_gen #(.PW(PW)) u_tick (
            .pclk(pclk), .presetn(presetn), .run(run),
            .ref_sel(cfg_q[c][B_REF]), .ref_rise(rise),
            .pre_sel(cfg_q[c][B_PRE]), .div(cfg_q[c][B_DIV +: PW]),
            .clr(rst_all[c]), .tick(tick[c])
        );

        // Config word: bus write, else one-shot stop then start strobe (start wins).
        always_ff @(posedge pclk) begin
            if (!presetn) cfg_q[c] <= '0;
            else if (wr[RI_CFG + c]) cfg_q[c] <= pwdata & KEEP;
            else begin
                if (land[c] && cfg_q[c][B_ONCE]) cfg_q[c][B_EN] <= 1'b0;
                if (wr[RI_GO + c])               cfg_q[c][B_EN] <= 1'b1;
            end
        end

        // Compare word: plain bus register.
        always_ff @(posedge pclk) begin
            if (!presetn)            cmp_q[c] <= '0;
            else if (wr[RI_CMP + c]) cmp_q[c] <= pwdata;
        end

        // Count word and landing pulse.
        always_ff @(posedge pclk) begin
            if (!presetn) begin
                cnt_q[c]  <= '0;
                irqp_q[c] <= 1'b0;
            end else begin
                cnt_q[c]  <= cnt_d[c];
                irqp_q[c] <= land[c] & cfg_q[c][B_IRQ];
            end
        end
    end

    // mtime level: joined count at or past joined compare.
    always_ff @(posedge pclk) begin
        if (!presetn) mt_q <= 1'b0;
        else          mt_q <= m64 & mt & (cnt64 >= cmp64);
    end

    assign irq_lo_o = (m64 && mt) ? mt_q : irqp_q[0];
    assign irq_hi_o = irqp_q[1];
    assign busy_o   = cfg_q[0][B_EN] | cfg_q[1][B_EN];
    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
endmodule

// File: rtl/tmr_apb_dual_chk.sv
// Property checker for the dual timer, attached by bind. Observes the bus,
// the stored config and count words and the outputs.
module tmr_apb_dual_chk #(
    parameter int ADDR_W = 12,
    parameter int DW     = 32
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DW-1:0]     prdata,
    input logic [DW-1:0]     cfg_lo,
    input logic [DW-1:0]     cnt_lo,
    input logic              irq_hi_o,
    input logic              busy_o
);
    logic bus_wr, is_strobe;
    assign bus_wr    = psel && penable && pwrite;
    assign is_strobe = (paddr >= ADDR_W'(24)) && (paddr <= ADDR_W'(36))
                       && (paddr[1:0] == 2'b00);

    AST_CLR_STROBE_ZEROES: assert property (@(posedge pclk) disable iff (!presetn)
        bus_wr && paddr == ADDR_W'(32) |=> cnt_lo == '0); // R10

    AST_GO_RAISES_BUSY: assert property (@(posedge pclk) disable iff (!presetn)
        bus_wr && paddr == ADDR_W'(24) |=> busy_o && cfg_lo[0]); // R11

    AST_STROBE_READS_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        psel && !pwrite && is_strobe |-> prdata == '0); // R10

    AST_IDLE_COUNT_HOLDS: assert property (@(posedge pclk) disable iff (!presetn)
        !cfg_lo[0] && !bus_wr |=> $stable(cnt_lo)); // R2

    AST_HI_IRQ_QUIET_64: assert property (@(posedge pclk) disable iff (!presetn)
        $past(cfg_lo[DW-1]) && cfg_lo[DW-1] |-> !irq_hi_o); // R7
endmodule

bind tmr_apb_dual tmr_apb_dual_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .cfg_lo(cfg_lo_w),
    .cnt_lo(cnt_lo_w), .irq_hi_o(irq_hi_o), .busy_o(busy_o)
);

// File: tb/sim_tmr_apb_dual.sv
`timescale 1ns/1ps
module sim_tmr_apb_dual;
    localparam int AW = 12;
    localparam logic [31:0] EN = 32'h1, RSTB = 32'h2, IRQ = 32'h4,
        WRAP = 32'h10, ONCE = 32'h20, PRE = 32'h40, REF = 32'h80,
        MT = 32'h4000_0000, M64 = 32'h8000_0000;

    logic clk = 0, rstn = 0;
    logic [AW-1:0] paddr = '0;
    logic psel = 0, penable = 0, pwrite = 0, refc = 0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, pslverr, irq_lo, irq_hi, busy;
    int n_chk = 0, n_fail = 0, n_lo = 0, n_hi = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_apb_dual #(.ADDR_W(AW)) u0 (
        .pclk(clk), .presetn(rstn), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ref_clk_i(refc),
        .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .busy_o(busy)
    );

    always @(negedge clk) begin
        if (irq_lo) n_lo++;
        if (irq_hi) n_hi++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = AW'(a); pwdata = d;
        @(negedge clk); penable = 1;
        @(posedge clk);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = AW'(a);
        @(negedge clk); penable = 1; #1 d = prdata;
        chk(pready && !pslverr, "R1 ready/err", {pready, pslverr}, 2'b10);
        @(posedge clk);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one channel for D idle cycles (D+3 base events) and returns the count.
    task automatic run_ch(input int ch, input logic [31:0] cfg, input int d,
                          output logic [31:0] cnt);
        wr(8'h20 + 4*ch, 0);
        wr(4*ch, cfg);
        idle(d);
        wr(4*ch, 0);
        rd(8'h08 + 4*ch, cnt);
    endtask

    initial begin
        logic [31:0] v, v2;
        int b_lo, b_hi, t;
        repeat (3) @(negedge clk);
        rstn = 1;
        // Reset state.
        rd(8'h00, v); chk(v == 0, "R1 cfg reset", v, 0);
        rd(8'h08, v); chk(v == 0, "R2 count reset", v, 0);
        chk(!busy && !irq_lo && !irq_hi, "R11 outputs reset", {busy, irq_lo, irq_hi}, 0);

        // R2/R3 sweep: both channels, prescaler off/on, divisors, run lengths.
        for (int ch = 0; ch < 2; ch++)
            for (int pe = 0; pe < 2; pe++)
                for (int dv = 0; dv < 3; dv++)
                    for (int d = 0; d < 5; d++) begin
                        run_ch(ch, EN | (pe ? PRE : 0) | (32'(dv) << 8), d, v);
                        t = pe ? (d + 3) / (dv + 1) : d + 3;
                        chk(v == 32'(t), pe ? "R3 prescaled count" : "R2 free count", v, t);
                    end

        // R5: compare-clear with interrupt pulses, both channels.
        for (int ch = 0; ch < 2; ch++)
            for (int c = 1; c < 4; c++)
                for (int k = 0; k < 2; k++) begin
                    int d = k ? 7 : 2;
                    wr(8'h10 + 4*ch, c);
                    b_lo = n_lo; b_hi = n_hi;
                    run_ch(ch, EN | IRQ | WRAP, d, v);
                    t = d + 3;
                    chk(v == 32'(t % (c + 1)), "R5 wrap count", v, t % (c + 1));
                    v2 = ch ? 32'(n_hi - b_hi) : 32'(n_lo - b_lo);
                    chk(v2 == 32'((t + 1) / (c + 1)), "R5 pulse total", v2, (t + 1) / (c + 1));
                    v2 = ch ? 32'(n_lo - b_lo) : 32'(n_hi - b_hi);
                    chk(v2 == 0, "R5 other channel quiet", v2, 0);
                end

        // R6: one-shot stops at compare.
        wr(8'h10, 4); wr(8'h20, 0);
        b_lo = n_lo;
        wr(8'h00, EN | IRQ | ONCE);
        idle(12);
        rd(8'h08, v); chk(v == 4, "R6 stops at compare", v, 4);
        rd(8'h00, v); chk(v == (IRQ | ONCE), "R6 enable cleared", v, IRQ | ONCE);
        chk(!busy, "R11 busy low after one-shot", busy, 0);
        chk(n_lo - b_lo == 1, "R6 single pulse", n_lo - b_lo, 1);
        wr(8'h00, 0);

        // R4: reference clock rising edges.
        wr(8'h20, 0);
        wr(8'h00, EN | REF);
        for (int k = 0; k < 5; k++) begin
            refc = 1; idle(4); refc = 0; idle(4);
        end
        idle(4);
        wr(8'h00, 0);
        rd(8'h08, v); chk(v == 5, "R4 ref edges", v, 5);

        // R10/R11: strobes.
        wr(8'h1C, 32'hFFFF_FFFF);
        chk(busy, "R11 busy after start", busy, 1);
        rd(8'h04, v); chk(v == EN, "R10 start sets enable", v, EN);
        rd(8'h1C, v); chk(v == 0, "R10 strobe reads 0", v, 0);
        wr(8'h04, 0);
        chk(!busy, "R11 busy low", busy, 0);
        wr(8'h24, 0);
        rd(8'h0C, v); chk(v == 0, "R10 clear strobe", v, 0);

        // R1: readback mask, compare, unmapped.
        wr(8'h14, 32'h1234_5678);
        rd(8'h14, v); chk(v == 32'h1234_5678, "R1 compare readback", v, 32'h1234_5678);
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h04, v); chk(v == 32'hC000_FFFC, "R1 config mask", v, 32'hC000_FFFC);
        wr(8'h04, 0);
        rd(8'h28, v); chk(v == 0, "R1 unmapped", v, 0);

        // R12: config reset bit and live overwrite.
        wr(8'h08, 55);
        wr(8'h00, RSTB);
        rd(8'h08, v); chk(v == 0, "R12 cfg reset clears", v, 0);
        rd(8'h00, v); chk(v == 0, "R12 reset bit reads 0", v, 0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h00, EN);
        wr(8'h08, 100);
        wr(8'h00, 0);
        rd(8'h08, v); chk(v == 103, "R12 live overwrite", v, 103);

        // R7: 64-bit carry into high word.
        wr(8'h08, 32'hFFFF_FFFD); wr(8'h0C, 5);
        wr(8'h00, M64 | EN); idle(2); wr(8'h00, M64);
        rd(8'h08, v); chk(v == 2, "R7 low word", v, 2);
        rd(8'h0C, v); chk(v == 6, "R7 carry", v, 6);

        // R8: 64-bit compare-clear.
        wr(8'h00, 0);
        wr(8'h08, 32'hFFFF_FFFE); wr(8'h0C, 6);
        wr(8'h10, 1); wr(8'h14, 7);
        b_lo = n_lo; b_hi = n_hi;
        wr(8'h00, M64 | WRAP | IRQ | EN); idle(2); wr(8'h00, M64);
        rd(8'h08, v); chk(v == 1, "R8 low after clear", v, 1);
        rd(8'h0C, v); chk(v == 0, "R8 high after clear", v, 0);
        chk(n_lo - b_lo == 1, "R7 pulse on low", n_lo - b_lo, 1);
        chk(n_hi - b_hi == 0, "R7 high quiet", n_hi - b_hi, 0);

        // R9: mtime level, enable and irq bits clear.
        wr(8'h00, M64 | MT);
        wr(8'h10, 10); wr(8'h14, 0); wr(8'h0C, 0); wr(8'h08, 9);
        idle(2); chk(!irq_lo, "R9 below compare", irq_lo, 0);
        wr(8'h08, 10);
        idle(2); chk(irq_lo, "R9 equal", irq_lo, 1);
        wr(8'h08, 11);
        idle(2); chk(irq_lo, "R9 above", irq_lo, 1);
        wr(8'h14, 1);
        idle(2); chk(!irq_lo, "R9 high compare word", irq_lo, 0);
        chk(!irq_hi, "R7 irq_hi low", irq_hi, 0);
        wr(8'h00, 0);
        chk(!busy, "R11 idle at end", busy, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule